// File: doc/BRIEF.md
# Hot-Swap Bus Join Sequencer

This block is the control core of a two-sided I2C/SMBus hot-swap buffer. A plug-in card carries one bus segment (the input side) and the backplane carries another (the output side). The block decides when the two segments may be tied together without corrupting a transfer that is already running on the backplane. It produces only the enables for the analog circuits: line precharge, the join between the two segments, and the rise-time accelerators.

Each side's supply monitor gives two comparator flags: one that reports the supply above the upper (turn-on) threshold, and one that reports it below the lower (turn-off) threshold. While either supply is not valid the block holds everything off. Once both supplies are valid it precharges the lines for a fixed settling period. It then arms a bus watcher, and joins the segments when all four lines have stayed high for the idle window, or sooner when a stop condition is seen on the card side while every line is high. All asynchronous inputs are synchronized internally.

Top module: `hsbuf_join_seq`

## Requirements
- R1: A side's supply counts as valid once its upper-threshold flag is 1. It stays valid while both of its flags are 0, and turns invalid only when its lower-threshold flag is 1. The two sides may become valid in either order.
- R2: Whenever either supply is invalid, the block returns to lockout from any state within 6 clock cycles.
- R3: In lockout, and out of reset, `precharge_en`, `join_en`, `accel_en` and `ready` are all 0.
- R4: Once both supplies are valid, `precharge_en` is 1 and `join_en` is 0 for INIT_CYCLES cycles before the bus watcher is armed. Line activity during this period cannot lead to a join.
- R5: When armed, the segments join once all four lines have been high for IDLE_CYCLES consecutive cycles. `join_en` is not asserted within IDLE_CYCLES cycles of the last line going high, and it is asserted within IDLE_CYCLES+4 cycles. Any line going low restarts the window.
- R6: When armed, a rising card-side SDA while card-side SCL stays high, with all four lines high, joins the segments within 6 cycles. An SDA rise while SCL is low, or while an output-side line is low, does not cause a join.
- R7: On joining, `precharge_en` drops to 0 in the same cycle that `join_en` and `ready` rise to 1.
- R8: While joined, `accel_en` equals the synchronized `accel_on_n`. It is 1 when the pin is 1 (including at the moment of joining) and 0 when the pin is 0. The pin never affects `join_en`.
- R9: Once joined, the block stays joined while both supplies are valid, whatever the line levels do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sup_card_above | input | 1 | Card supply above upper threshold |
| sup_card_below | input | 1 | Card supply below lower threshold |
| sup_bp_above | input | 1 | Backplane supply above upper threshold |
| sup_bp_below | input | 1 | Backplane supply below lower threshold |
| card_sda | input | 1 | Card-side SDA level |
| card_scl | input | 1 | Card-side SCL level |
| bp_sda | input | 1 | Backplane-side SDA level |
| bp_scl | input | 1 | Backplane-side SCL level |
| accel_on_n | input | 1 | Accelerator permit; 0 keeps the accelerators off |
| precharge_en | output | 1 | Enable for line precharge |
| join_en | output | 1 | Enable for the segment join |
| accel_en | output | 1 | Enable for the rise-time accelerators |
| ready | output | 1 | Segments joined |

## Verification
The bench goes after premature joining. It holds the lines high through the precharge period: a watcher armed too early would join about INIT_CYCLES early. It pulses one backplane line low midway through the idle window: a counter that is not restarted would join half a window early. It also sends near-stop patterns (SDA rising under a low SCL, or with a backplane line low), which a loose stop detector would accept. On the supply side it checks hysteresis, where a design keyed to the upper flag alone drops out between thresholds. It also checks a collapse after joining, which must clear all three enables, and toggles the accelerator pin while joined, which must not disturb the join.

// File: rtl/hsj_pkg.sv
package hsj_pkg;

  typedef enum logic [1:0] {
    ST_LOCKOUT = 2'd0,
    ST_PRECHG  = 2'd1,
    ST_ARMED   = 2'd2,
    ST_JOINED  = 2'd3
  } hsj_state_e;

  // Hysteretic qualifier: lower flag wins, upper flag sets, else hold.
  function automatic logic qual_update(input logic cur, input logic above, input logic below);
    if (below)      return 1'b0;
    else if (above) return 1'b1;
    else            return cur;
  endfunction

  // Stop condition: data rises while clock is high on both samples.
  function automatic logic is_stop(input logic sda_prev, input logic sda_now,
                                   input logic scl_prev, input logic scl_now);
    return !sda_prev && sda_now && scl_prev && scl_now;
  endfunction

  function automatic hsj_state_e hsj_next(input hsj_state_e cur, input logic sup_ok,
                                          input logic init_done, input logic join_req);
    hsj_state_e nx;
    nx = cur;
    if (!sup_ok) nx = ST_LOCKOUT;
    else begin
      case (cur)
        ST_LOCKOUT: nx = ST_PRECHG;
        ST_PRECHG:  nx = init_done ? ST_ARMED : ST_PRECHG;
        ST_ARMED:   nx = join_req ? ST_JOINED : ST_ARMED;
        default:    nx = ST_JOINED;
      endcase
    end
    return nx;
  endfunction

endpackage

// File: rtl/hsj_sync.sv
module hsj_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/hsj_supply_qual.sv
module hsj_supply_qual
  import hsj_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic above,
  input  logic below,
  output logic valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid <= 1'b0;
    else        valid <= qual_update(valid, above, below);
  end

  AST_QUAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!above && !below) |=> (valid == $past(valid)));  // R1
  AST_QUAL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    below |=> !valid);  // R2
endmodule

// File: rtl/hsj_bus_watch.sv
module hsj_bus_watch
  import hsj_pkg::*;
#(
  parameter int IDLE_CYCLES = 25000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       armed,
  input  logic [3:0] lines,    // [0] card SDA, [1] card SCL, [2] bp SDA, [3] bp SCL
  output logic       idle_hit,
  output logic       stop_hit
);
  localparam int CW = $clog2(IDLE_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(IDLE_CYCLES - 1);

  logic [CW-1:0] idle_cnt;
  logic          sda_prev, scl_prev;
  logic          all_high;

  assign all_high = &lines;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idle_cnt <= '0;
    else if (!armed || !all_high) idle_cnt <= '0;
    else if (idle_cnt != LAST) idle_cnt <= idle_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_prev <= 1'b0;
      scl_prev <= 1'b0;
    end else begin
      sda_prev <= lines[0];
      scl_prev <= lines[1];
    end
  end

  assign idle_hit = armed && all_high && (idle_cnt == LAST);
  assign stop_hit = armed && all_high && is_stop(sda_prev, lines[0], scl_prev, lines[1]);

  AST_IDLE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !all_high) |=> (idle_cnt == '0));  // R5
  AST_STOP_ALL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    stop_hit |-> ($past(lines[1]) && !$past(lines[0])));  // R6
endmodule

// File: rtl/hsbuf_join_seq.sv
module hsbuf_join_seq
  import hsj_pkg::*;
#(
  parameter int IDLE_CYCLES = 25000,
  parameter int INIT_CYCLES = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sup_card_above,
  input  logic sup_card_below,
  input  logic sup_bp_above,
  input  logic sup_bp_below,
  input  logic card_sda,
  input  logic card_scl,
  input  logic bp_sda,
  input  logic bp_scl,
  input  logic accel_on_n,
  output logic precharge_en,
  output logic join_en,
  output logic accel_en,
  output logic ready
);
  localparam int NSIDES = 2;
  localparam int NIN    = 2 * NSIDES + 4 + 1;
  localparam int ICW    = $clog2(INIT_CYCLES + 1);
  localparam logic [ICW-1:0] INIT_LAST = ICW'(INIT_CYCLES - 1);

  logic [NIN-1:0]    raw_in, syn_in;
  logic [NSIDES-1:0] sup_above, sup_below, sup_valid;
  logic [3:0]        lines_s;
  logic              accel_pin_s;
  logic              supplies_ok, init_done, join_req, idle_hit, stop_hit, armed;
  logic [ICW-1:0]    init_cnt;
  hsj_state_e        state;

  assign raw_in = {accel_on_n, bp_scl, bp_sda, card_scl, card_sda,
                   sup_bp_below, sup_bp_above, sup_card_below, sup_card_above};

  hsj_sync #(.WIDTH(NIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
  );

  assign lines_s     = syn_in[7:4];
  assign accel_pin_s = syn_in[8];

  for (genvar s = 0; s < NSIDES; s++) begin : g_side
    assign sup_above[s] = syn_in[2*s];
    assign sup_below[s] = syn_in[2*s+1];
    hsj_supply_qual u_qual (
      .clk(clk), .rst_n(rst_n),
      .above(sup_above[s]), .below(sup_below[s]), .valid(sup_valid[s])
    );
  end

  assign supplies_ok = &sup_valid;
  assign armed       = (state == ST_ARMED);

  hsj_bus_watch #(.IDLE_CYCLES(IDLE_CYCLES)) u_watch (
    .clk(clk), .rst_n(rst_n), .armed(armed), .lines(lines_s),
    .idle_hit(idle_hit), .stop_hit(stop_hit)
  );

  assign join_req = idle_hit || stop_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) init_cnt <= '0;
    else if (state != ST_PRECHG) init_cnt <= '0;
    else if (init_cnt != INIT_LAST) init_cnt <= init_cnt + 1'b1;
  end

  assign init_done = (state == ST_PRECHG) && (init_cnt == INIT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_LOCKOUT;
    else        state <= hsj_next(state, supplies_ok, init_done, join_req);
  end

  assign precharge_en = (state == ST_PRECHG) || (state == ST_ARMED);
  assign join_en      = (state == ST_JOINED);
  assign ready        = (state == ST_JOINED);
  assign accel_en     = (state == ST_JOINED) && accel_pin_s;

  AST_LOCKOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !supplies_ok |=> (!join_en && !precharge_en && !accel_en && !ready));  // R3
  AST_ARM_AFTER_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(state == ST_PRECHG));  // R4
  AST_JOIN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(join_en) |-> $past(join_req && supplies_ok));  // R6
  AST_NO_PRECHG_JOINED: assert property (@(posedge clk) disable iff (!rst_n)
    !(precharge_en && join_en));  // R7
  AST_ACCEL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    accel_en |-> (join_en && accel_pin_s));  // R8
  AST_JOIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (join_en && supplies_ok) |=> join_en);  // R9
endmodule

// File: tb/hsbuf_join_seq_tb_top.sv
`timescale 1ns/1ps
module hsbuf_join_seq_tb_top;
  localparam int IDLE = 40;
  localparam int INIT = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ca, cb, ba, bb, csda, cscl, bsda, bscl, acc_n;
  logic pre, jn, acc, rdy;
  int   n_checks = 0;
  int   n_errors = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  hsbuf_join_seq #(.IDLE_CYCLES(IDLE), .INIT_CYCLES(INIT), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .sup_card_above(ca), .sup_card_below(cb), .sup_bp_above(ba), .sup_bp_below(bb),
    .card_sda(csda), .card_scl(cscl), .bp_sda(bsda), .bp_scl(bscl),
    .accel_on_n(acc_n),
    .precharge_en(pre), .join_en(jn), .accel_en(acc), .ready(rdy)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic set_lines(input logic v);
    csda = v; cscl = v; bsda = v; bscl = v;
  endtask

  // supplies off, lines low, then both supplies up; leaves block armed
  task automatic power_cycle_and_arm();
    ca = 0; cb = 1; ba = 0; bb = 1; set_lines(0);
    cyc(8);
    cb = 0; bb = 0; ca = 1; ba = 1;
    cyc(INIT + 10);
  endtask

  task automatic t_reset();
    chk("R3 reset precharge", pre, 0);
    chk("R3 reset join", jn, 0);
    chk("R3 reset accel", acc, 0);
    chk("R3 reset ready", rdy, 0);
  endtask

  task automatic t_order_hyst();
    ca = 0; cb = 0; ba = 0; bb = 1; set_lines(0);
    cyc(2); ca = 1; cyc(2); ca = 0; cyc(8);
    chk("R1 one side only stays locked", pre, 0);
    bb = 0; ba = 1; cyc(2); ba = 0; cyc(6);
    chk("R1 either order and hysteresis give precharge", pre, 1);
    chk("R4 no join during precharge", jn, 0);
  endtask

  task automatic t_init_guard();
    ca = 0; cb = 1; ba = 0; bb = 1; set_lines(1);
    cyc(8);
    cb = 0; bb = 0; ca = 1; ba = 1;
    cyc(6);
    chk("R4 precharge on after supplies valid", pre, 1);
    cyc(INIT + IDLE + 2 - 6);
    chk("R4 watcher not armed during init", jn, 0);
    cyc(4);
    chk("R4 joins after init plus idle", jn, 1);
  endtask

  task automatic t_idle();
    power_cycle_and_arm();
    set_lines(1);
    cyc(IDLE / 2);
    bscl = 0; cyc(2); bscl = 1;
    cyc(IDLE);
    chk("R5 no join before idle window ends", jn, 0);
    cyc(4);
    chk("R5 join after restarted idle window", jn, 1);
    chk("R7 precharge off when joined", pre, 0);
    chk("R7 ready when joined", rdy, 1);
    chk("R8 accel on at join with pin high", acc, 1);
  endtask

  task automatic t_stop();
    power_cycle_and_arm();
    bsda = 1; bscl = 1; cscl = 1; csda = 0;
    cyc(4);
    csda = 1;
    cyc(1);
    chk("R6 not joined before stop reaches watcher", jn, 0);
    cyc(5);
    chk("R6 stop joins", jn, 1);
    chk("R7 precharge dropped on stop join", pre, 0);
  endtask

  task automatic t_not_stop();
    power_cycle_and_arm();
    bsda = 1; bscl = 1; cscl = 0; csda = 0;
    cyc(4); csda = 1; cyc(3); cscl = 1;
    cyc(10);
    chk("R6 SDA rise under low SCL is no stop", jn, 0);
    power_cycle_and_arm();
    bsda = 0; bscl = 1; cscl = 1; csda = 0;
    cyc(4); csda = 1;
    cyc(10);
    chk("R6 stop with backplane SDA low ignored", jn, 0);
  endtask

  task automatic t_accel_and_hold();
    power_cycle_and_arm();
    acc_n = 0;
    set_lines(1);
    cyc(IDLE + 6);
    chk("R8 join with pin low", jn, 1);
    chk("R8 accel off with pin low", acc, 0);
    acc_n = 1; cyc(4);
    chk("R8 accel follows pin high", acc, 1);
    acc_n = 0; cyc(4);
    chk("R8 accel follows pin low", acc, 0);
    chk("R8 pin leaves join intact", jn, 1);
    acc_n = 1;
    set_lines(0); cyc(6); cscl = 1; cyc(3); set_lines(1); cyc(4);
    chk("R9 joined through line activity", jn, 1);
    ca = 0; ba = 0; cyc(10);
    chk("R1 valid held between thresholds", jn, 1);
    bb = 1; cyc(6);
    chk("R2 join dropped on backplane collapse", jn, 0);
    chk("R2 accel dropped on collapse", acc, 0);
    chk("R3 precharge off in lockout", pre, 0);
    chk("R3 ready off in lockout", rdy, 0);
  endtask

  initial begin
    ca = 0; cb = 1; ba = 0; bb = 1; set_lines(0); acc_n = 1;
    cyc(3);
    t_reset();
    rst_n = 1'b1;
    cyc(3);
    t_reset();
    t_order_hyst();
    t_init_guard();
    t_idle();
    t_stop();
    t_not_stop();
    t_accel_and_hold();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule